// File: doc/BRIEF.md
# Shadowed Configuration Register Bank for a Camera Pixel Pipeline

This block is the configuration store of a raw-camera pixel pipeline. It sits on an AXI4-Lite slave port of 32-bit data and 5-bit address. It holds four white-balance gains, one for each site of the Bayer pattern, nine colour-matrix coefficients and a black-level offset. Two 16-bit fields are packed into each 32-bit word. Software writes land only in a pending copy. The pipeline sees a second, active copy. The active copy is reloaded from the pending copy as a whole, and only when a start-of-frame beat is accepted on the pipeline's AXI4-Stream video input. The block watches that input but does not drive it.

The block is placed next to the pipeline's input stage. Its `vid_*` inputs tap the valid, ready and tuser wires of that stream. Its active outputs feed the black-level, gain and matrix stages. Settings therefore never change in the middle of a frame, however software times its writes. Reads return the pending copy, so software sees what it has programmed even before that takes effect.

Top module: `cfg_shadow_bank`

## Requirements
- R1: While reset is asserted, both copies load their defaults. Each of the four gains is 0x0080. The matrix terms rr, gg and bb are 0x1000 and the other six terms are 0. The black level is 0x0100.
- R2: The word index is address bits [4:2]. Word 0 is {blue gain, red gain}, word 1 is {green1 gain, green0 gain}, and word 6 is {black level, coefficient bb}, upper half first. Matrix coefficient k, counted in the order rr, rg, rb, gr, gg, gb, br, bg, bb, is kept in word 2+k/2, in bits [15:0] when k is even and in [31:16] when k is odd. It appears on `ccm_coef[16k+15:16k]`.
- R3: Write strobe bit i updates byte i (bits [8i+7:8i]) of the addressed word. A byte whose strobe is low keeps its old value.
- R4: A read returns the pending copy of the addressed word. Word index 7 (address 0x1C) reads as zero, and a write to it changes no register.
- R5: The active outputs change only in the cycle after a start-of-frame beat, which is `vid_tvalid`, `vid_tready` and `vid_tuser` all high at a clock edge. A beat that lacks any one of the three has no effect.
- R6: On a start-of-frame beat, every active field takes the value its pending field held before that edge. A write accepted at the same edge reaches the active copy only at the following start of frame.
- R7: `awready` and `wready` are high together, and only while `awvalid` and `wvalid` are both high and no write response is outstanding. `bvalid` rises in the cycle after acceptance and stays high until `bready` is seen.
- R8: `arready` is high while no read data is outstanding. `rvalid` rises in the cycle after acceptance, and `rdata` stays unchanged until `rready` is seen.
- R9: `bresp` and `rresp` are always 2'b00 (OKAY).
- R10: The reset is synchronous and active-low. It restores both copies to their defaults and drops `bvalid` and `rvalid`, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register port and the video stream |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | 5 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| araddr | input | 5 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data from the pending copy |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| vid_tvalid | input | 1 | Monitored video stream valid |
| vid_tready | input | 1 | Monitored video stream ready |
| vid_tuser | input | 1 | Monitored start-of-frame flag |
| gain_red | output | 16 | Active red gain |
| gain_blue | output | 16 | Active blue gain |
| gain_green0 | output | 16 | Active gain of the first green site |
| gain_green1 | output | 16 | Active gain of the second green site |
| ccm_coef | output | 144 | Active colour-matrix terms, 16 bits each, ordered as in R2 |
| black_level | output | 16 | Active black-level offset |

## Verification
The bench aims at the write that is accepted at the same clock edge as a start-of-frame beat. A design that forwards the new data straight into the active copy would show the new value one frame early. The bench sends stream beats with tready or tuser low, and a design that decoded the frame start from tuser alone would reload on them. Partial strobes, including all strobes low, catch a design that writes whole words. The write to address 0x1C catches an index decode that wraps onto a real word. With `bready` and `rready` held low, the bench shows whether a design drops its response, changes `rdata`, or accepts a second transfer while one is still outstanding.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int unsigned CFG_DATA_W    = 32;
  localparam int unsigned CFG_ADDR_W    = 5;
  localparam int unsigned CFG_FIELD_W   = 16;
  localparam int unsigned CFG_NUM_WORDS = 7;
  localparam int unsigned CFG_NUM_COEF  = 9;
  localparam int unsigned CFG_STRB_W    = CFG_DATA_W / 8;
  localparam int unsigned CFG_FLAT_W    = CFG_NUM_WORDS * CFG_DATA_W;
  localparam int unsigned CFG_COEF_BASE = 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  localparam logic [CFG_FIELD_W-1:0] GAIN_UNITY  = 16'h0080;
  localparam logic [CFG_FIELD_W-1:0] COEF_UNITY  = 16'h1000;
  localparam logic [CFG_FIELD_W-1:0] BLACK_RESET = 16'h0100;

  typedef logic [CFG_DATA_W-1:0] cfg_word_t;

  // Reset content of word idx: {upper field, lower field}
  function automatic cfg_word_t cfg_default_word(input int unsigned idx);
    cfg_word_t w;
    case (idx)
      0, 1:    w = {GAIN_UNITY, GAIN_UNITY};
      2:       w = {16'h0000, COEF_UNITY};   // rg | rr
      4:       w = {16'h0000, COEF_UNITY};   // gb | gg
      6:       w = {BLACK_RESET, COEF_UNITY}; // black | bb
      default: w = '0;                        // words 3 and 5: off-diagonal
    endcase
    return w;
  endfunction

  // Byte-granular merge of new data into an old word
  function automatic cfg_word_t cfg_merge_strb(input cfg_word_t old_w,
                                               input cfg_word_t new_w,
                                               input logic [CFG_STRB_W-1:0] strb);
    cfg_word_t r;
    r = old_w;
    for (int b = 0; b < int'(CFG_STRB_W); b++) begin
      if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_wr_port.sv
module cfg_wr_port
  import cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = CFG_ADDR_W,
  parameter int unsigned DATA_W = CFG_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  output logic                wr_fire,
  output logic [ADDR_W-3:0]   wr_index,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] wr_strb
);

  logic bvalid_q;
  logic accept;

  // Address and data must arrive together; nothing new while a response waits
  assign accept  = awvalid & wvalid & ~bvalid_q;
  assign awready = accept;
  assign wready  = accept;

  assign wr_fire  = accept;
  assign wr_index = awaddr[ADDR_W-1:2];
  assign wr_data  = wdata;
  assign wr_strb  = wstrb;

  logic [1:0] unused_aw_low;
  assign unused_aw_low = awaddr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)        bvalid_q <= 1'b0;
    else if (accept)   bvalid_q <= 1'b1;
    else if (bready)   bvalid_q <= 1'b0;
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;

endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = CFG_ADDR_W,
  parameter int unsigned DATA_W    = CFG_DATA_W,
  parameter int unsigned NUM_WORDS = CFG_NUM_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             araddr,
  input  logic                          arvalid,
  output logic                          arready,
  output logic [DATA_W-1:0]             rdata,
  output logic [1:0]                    rresp,
  output logic                          rvalid,
  input  logic                          rready,
  input  logic [NUM_WORDS*DATA_W-1:0]   shadow_flat
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] sel_word;
  logic [IDX_W-1:0]  rd_index;
  logic              rd_fire;

  assign rd_index = araddr[ADDR_W-1:2];
  assign arready  = ~rvalid_q;
  assign rd_fire  = arvalid & ~rvalid_q;

  logic [1:0] unused_ar_low;
  assign unused_ar_low = araddr[1:0];

  // Unmapped indices fall through to zero
  always_comb begin
    sel_word = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (rd_index == IDX_W'(w)) sel_word = shadow_flat[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= sel_word;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfg_pkg::*;
#(
  parameter int unsigned IDX_W     = CFG_ADDR_W - 2,
  parameter int unsigned DATA_W    = CFG_DATA_W,
  parameter int unsigned NUM_WORDS = CFG_NUM_WORDS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [IDX_W-1:0]            wr_index,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [DATA_W/8-1:0]         wr_strb,
  input  logic                        sof,
  output logic [NUM_WORDS*DATA_W-1:0] shadow_flat,
  output logic [NUM_WORDS*DATA_W-1:0] active_flat
);

  for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_word
    logic [DATA_W-1:0] shd_q;
    logic [DATA_W-1:0] act_q;
    logic              hit;

    assign hit = wr_fire && (wr_index == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_q <= cfg_default_word(w);
        act_q <= cfg_default_word(w);
      end else begin
        if (hit) shd_q <= cfg_merge_strb(shd_q, wr_data, wr_strb);
        // Nonblocking copy takes the pre-write pending value
        if (sof) act_q <= shd_q;
      end
    end

    assign shadow_flat[w*DATA_W +: DATA_W] = shd_q;
    assign active_flat[w*DATA_W +: DATA_W] = act_q;
  end

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = CFG_ADDR_W,
  parameter int unsigned DATA_W  = CFG_DATA_W,
  parameter int unsigned FIELD_W = CFG_FIELD_W,
  parameter int unsigned NCOEF   = CFG_NUM_COEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      awaddr,
  input  logic                   awvalid,
  output logic                   awready,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [DATA_W/8-1:0]    wstrb,
  input  logic                   wvalid,
  output logic                   wready,
  output logic [1:0]             bresp,
  output logic                   bvalid,
  input  logic                   bready,
  input  logic [ADDR_W-1:0]      araddr,
  input  logic                   arvalid,
  output logic                   arready,
  output logic [DATA_W-1:0]      rdata,
  output logic [1:0]             rresp,
  output logic                   rvalid,
  input  logic                   rready,
  input  logic                   vid_tvalid,
  input  logic                   vid_tready,
  input  logic                   vid_tuser,
  output logic [FIELD_W-1:0]     gain_red,
  output logic [FIELD_W-1:0]     gain_blue,
  output logic [FIELD_W-1:0]     gain_green0,
  output logic [FIELD_W-1:0]     gain_green1,
  output logic [NCOEF*FIELD_W-1:0] ccm_coef,
  output logic [FIELD_W-1:0]     black_level
);

  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NWORDS = CFG_COEF_BASE + (NCOEF + 1) / 2;
  localparam int unsigned FLAT_W = NWORDS * DATA_W;

  logic                   sof_event;
  logic                   wr_fire;
  logic [IDX_W-1:0]       wr_index;
  logic [DATA_W-1:0]      wr_data;
  logic [DATA_W/8-1:0]    wr_strb;
  logic [FLAT_W-1:0]      shadow_flat;
  logic [FLAT_W-1:0]      active_flat;

  // Frame start: an accepted stream beat flagged with tuser
  assign sof_event = vid_tvalid & vid_tready & vid_tuser;

  cfg_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .awaddr   (awaddr),
    .awvalid  (awvalid),
    .awready  (awready),
    .wdata    (wdata),
    .wstrb    (wstrb),
    .wvalid   (wvalid),
    .wready   (wready),
    .bresp    (bresp),
    .bvalid   (bvalid),
    .bready   (bready),
    .wr_fire  (wr_fire),
    .wr_index (wr_index),
    .wr_data  (wr_data),
    .wr_strb  (wr_strb)
  );

  cfg_reg_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_WORDS(NWORDS)) i_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire     (wr_fire),
    .wr_index    (wr_index),
    .wr_data     (wr_data),
    .wr_strb     (wr_strb),
    .sof         (sof_event),
    .shadow_flat (shadow_flat),
    .active_flat (active_flat)
  );

  cfg_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NWORDS)) i_rd_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .araddr      (araddr),
    .arvalid     (arvalid),
    .arready     (arready),
    .rdata       (rdata),
    .rresp       (rresp),
    .rvalid      (rvalid),
    .rready      (rready),
    .shadow_flat (shadow_flat)
  );

  // Gains: word 0 = {blue, red}, word 1 = {green1, green0}
  assign gain_red    = active_flat[0*DATA_W +: FIELD_W];
  assign gain_blue   = active_flat[0*DATA_W + FIELD_W +: FIELD_W];
  assign gain_green0 = active_flat[1*DATA_W +: FIELD_W];
  assign gain_green1 = active_flat[1*DATA_W + FIELD_W +: FIELD_W];

  // Coefficient k sits in word base+k/2, lower half for even k
  for (genvar k = 0; k < int'(NCOEF); k++) begin : g_coef
    assign ccm_coef[k*FIELD_W +: FIELD_W] =
      active_flat[(CFG_COEF_BASE + k/2)*DATA_W + (k%2)*FIELD_W +: FIELD_W];
  end

  // Black level shares the last word with the final coefficient
  assign black_level = active_flat[(NWORDS-1)*DATA_W + FIELD_W +: FIELD_W];

endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk #(
  parameter int unsigned FLAT_W = 224,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              wvalid,
  input logic              awready,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              sof_event,
  input logic              wr_fire,
  input logic [FLAT_W-1:0] shadow_flat,
  input logic [FLAT_W-1:0] active_flat
);

  assert_resp_okay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bresp == 2'b00) && (rresp == 2'b00));

  assert_ready_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    awready == wready);

  assert_accept_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    awready |-> (awvalid && wvalid && !bvalid));

  assert_bresp_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bvalid);

  assert_bvalid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_event |=> $stable(active_flat));

  assert_active_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_event |=> (active_flat == $past(shadow_flat)));

endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(.FLAT_W(FLAT_W), .DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .awvalid     (awvalid),
  .wvalid      (wvalid),
  .awready     (awready),
  .wready      (wready),
  .bvalid      (bvalid),
  .bready      (bready),
  .bresp       (bresp),
  .rvalid      (rvalid),
  .rready      (rready),
  .rdata       (rdata),
  .rresp       (rresp),
  .sof_event   (sof_event),
  .wr_fire     (wr_fire),
  .shadow_flat (shadow_flat),
  .active_flat (active_flat)
);

// File: tb/test_cfg_shadow_bank.sv
`timescale 1ns/1ps
module test_cfg_shadow_bank;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   awaddr = '0;
  logic         awvalid = 1'b0;
  logic         awready;
  logic [31:0]  wdata = '0;
  logic [3:0]   wstrb = '0;
  logic         wvalid = 1'b0;
  logic         wready;
  logic [1:0]   bresp;
  logic         bvalid;
  logic         bready = 1'b1;
  logic [4:0]   araddr = '0;
  logic         arvalid = 1'b0;
  logic         arready;
  logic [31:0]  rdata;
  logic [1:0]   rresp;
  logic         rvalid;
  logic         rready = 1'b1;
  logic         vid_tvalid = 1'b0;
  logic         vid_tready = 1'b0;
  logic         vid_tuser = 1'b0;
  logic [15:0]  gain_red, gain_blue, gain_green0, gain_green1, black_level;
  logic [143:0] ccm_coef;

  always #4 clk = ~clk;  // 125 MHz

  cfg_shadow_bank i_cfg_shadow_bank (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .vid_tvalid(vid_tvalid), .vid_tready(vid_tready), .vid_tuser(vid_tuser),
    .gain_red(gain_red), .gain_blue(gain_blue),
    .gain_green0(gain_green0), .gain_green1(gain_green1),
    .ccm_coef(ccm_coef), .black_level(black_level)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] pend_m [8];
  logic [31:0] act_m  [8];
  logic [31:0] rd_q [$];
  string rd_tag [$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) pend_m[i] = 32'h0;
    pend_m[0] = 32'h0080_0080;
    pend_m[1] = 32'h0080_0080;
    pend_m[2] = 32'h0000_1000;
    pend_m[4] = 32'h0000_1000;
    pend_m[6] = 32'h0100_1000;
    for (int i = 0; i < 8; i++) act_m[i] = pend_m[i];
  endtask

  function automatic logic [31:0] bytes_merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  // Expected coefficient from the model, named by row and column
  function automatic logic [15:0] exp_coef(int k);
    case (k)
      0: return act_m[2][15:0];   // rr
      1: return act_m[2][31:16];  // rg
      2: return act_m[3][15:0];   // rb
      3: return act_m[3][31:16];  // gr
      4: return act_m[4][15:0];   // gg
      5: return act_m[4][31:16];  // gb
      6: return act_m[5][15:0];   // br
      7: return act_m[5][31:16];  // bg
      default: return act_m[6][15:0]; // bb
    endcase
  endfunction

  task automatic check_active(string req);
    chk(req, "gain_red",    {16'h0, gain_red},    {16'h0, act_m[0][15:0]});
    chk(req, "gain_blue",   {16'h0, gain_blue},   {16'h0, act_m[0][31:16]});
    chk(req, "gain_green0", {16'h0, gain_green0}, {16'h0, act_m[1][15:0]});
    chk(req, "gain_green1", {16'h0, gain_green1}, {16'h0, act_m[1][31:16]});
    chk(req, "black_level", {16'h0, black_level}, {16'h0, act_m[6][31:16]});
    for (int k = 0; k < 9; k++)
      chk(req, $sformatf("coef%0d", k), {16'h0, ccm_coef[16*k +: 16]}, {16'h0, exp_coef(k)});
  endtask

  task automatic wait_nb();
    @(negedge clk); #1;
  endtask

  // Write; with_sof also presents a start-of-frame beat in the accepting cycle
  task automatic do_write(logic [4:0] a, logic [31:0] d, logic [3:0] s, bit with_sof);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    while (!awready) wait_nb();
    if (with_sof) begin
      vid_tvalid = 1'b1; vid_tready = 1'b1; vid_tuser = 1'b1;
    end
    @(posedge clk);
    if (with_sof) for (int i = 0; i < 8; i++) act_m[i] = pend_m[i];
    if (a[4:2] != 3'd7) pend_m[a[4:2]] = bytes_merge(pend_m[a[4:2]], d, s);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    vid_tvalid = 1'b0; vid_tready = 1'b0; vid_tuser = 1'b0;
    #1;
    chk("R7", "bvalid after accept", {31'h0, bvalid}, 32'h1);
    chk("R9", "bresp", {30'h0, bresp}, 32'h0);
  endtask

  // Read: expected value queued before the accepting edge, monitor compares
  task automatic do_read(logic [4:0] a, string req);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    #1;
    while (!arready) wait_nb();
    rd_q.push_back(a[4:2] == 3'd7 ? 32'h0 : pend_m[a[4:2]]);
    rd_tag.push_back(req);
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
  endtask

  task automatic stream_beat(logic v, logic r, logic u);
    @(negedge clk);
    vid_tvalid = v; vid_tready = r; vid_tuser = u;
    @(posedge clk);
    if (v && r && u) for (int i = 0; i < 8; i++) act_m[i] = pend_m[i];
    @(negedge clk);
    vid_tvalid = 1'b0; vid_tready = 1'b0; vid_tuser = 1'b0;
  endtask

  // Monitor: pops expected read data when a read beat completes
  always begin
    @(negedge clk); #1;
    if (rst_n && rvalid && rready) begin
      if (rd_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected read beat actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag.pop_front();
        chk(t, "rdata", rdata, e);
        chk("R9", "rresp", {30'h0, rresp}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_nb();

    // R1 / R10: reset state on outputs and handshakes
    chk("R10", "bvalid after reset", {31'h0, bvalid}, 32'h0);
    chk("R10", "rvalid after reset", {31'h0, rvalid}, 32'h0);
    check_active("R1");
    for (int i = 0; i < 8; i++) do_read(5'(i*4), (i == 7) ? "R4" : "R1");

    // R5 / R4: pending write visible to reads but not to outputs
    do_write(5'h00, 32'h0123_0456, 4'hF, 1'b0);
    do_write(5'h04, 32'h0789_0ABC, 4'hF, 1'b0);
    wait_nb();
    check_active("R5");
    do_read(5'h00, "R4");
    do_read(5'h04, "R4");

    // R5: incomplete frame-start beats are ignored
    stream_beat(1'b1, 1'b0, 1'b1); wait_nb(); check_active("R5");
    stream_beat(1'b1, 1'b1, 1'b0); wait_nb(); check_active("R5");
    stream_beat(1'b0, 1'b1, 1'b1); wait_nb(); check_active("R5");

    // R6 / R2: frame start loads everything, mapping checked field by field
    stream_beat(1'b1, 1'b1, 1'b1); wait_nb(); check_active("R6");
    do_write(5'h08, 32'h1111_2222, 4'hF, 1'b0);
    do_write(5'h0C, 32'h3333_4444, 4'hF, 1'b0);
    do_write(5'h10, 32'h5555_6666, 4'hF, 1'b0);
    do_write(5'h14, 32'h7777_8888, 4'hF, 1'b0);
    do_write(5'h18, 32'h0ABC_9999, 4'hF, 1'b0);
    stream_beat(1'b1, 1'b1, 1'b1); wait_nb(); check_active("R2");
    chk("R2", "coef rb literal", {16'h0, ccm_coef[32 +: 16]}, 32'h4444);
    chk("R2", "black literal", {16'h0, black_level}, 32'h0ABC);

    // R3: byte strobes
    do_write(5'h10, 32'hAABB_CCDD, 4'b0101, 1'b0);
    do_read(5'h10, "R3");
    do_write(5'h14, 32'hFFFF_FFFF, 4'b0000, 1'b0);
    do_read(5'h14, "R3");
    do_write(5'h00, 32'hDEAD_BEEF, 4'b1000, 1'b0);
    do_read(5'h00, "R3");
    stream_beat(1'b1, 1'b1, 1'b1); wait_nb(); check_active("R3");

    // R4: word 7 reads zero and writes to it hit nothing
    do_write(5'h1C, 32'hFFFF_FFFF, 4'hF, 1'b0);
    for (int i = 0; i < 8; i++) do_read(5'(i*4), "R4");

    // R6: write in the same cycle as frame start is deferred one frame
    do_write(5'h18, 32'h0200_0F00, 4'hF, 1'b1);
    wait_nb();
    check_active("R6");
    chk("R6", "black still old", {16'h0, black_level}, 32'h0ABC);
    stream_beat(1'b1, 1'b1, 1'b1); wait_nb();
    chk("R6", "black after next frame", {16'h0, black_level}, 32'h0200);

    // R7: response held while bready low, no second accept
    @(negedge clk); bready = 1'b0;
    do_write(5'h08, 32'h0000_1234, 4'hF, 1'b0);
    @(negedge clk);
    awaddr = 5'h0C; wdata = 32'h9999_9999; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      wait_nb();
      chk("R7", "bvalid held", {31'h0, bvalid}, 32'h1);
      chk("R7", "awready blocked", {31'h0, awready}, 32'h0);
      chk("R7", "wready blocked", {31'h0, wready}, 32'h0);
    end
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0; bready = 1'b1;
    wait_nb();
    chk("R7", "bvalid cleared", {31'h0, bvalid}, 32'h0);
    do_read(5'h0C, "R7");

    // R8: read data held while rready low
    @(negedge clk); rready = 1'b0;
    do_read(5'h08, "R8");
    for (int c = 0; c < 3; c++) begin
      wait_nb();
      chk("R8", "rvalid held", {31'h0, rvalid}, 32'h1);
      chk("R8", "rdata held", rdata, pend_m[2]);
      chk("R8", "arready low", {31'h0, arready}, 32'h0);
    end
    @(negedge clk); rready = 1'b1;
    repeat (3) wait_nb();

    // R10: reset in mid-run restores defaults
    do_write(5'h00, 32'h0F0F_0F0F, 4'hF, 1'b1);
    @(negedge clk); bready = 1'b0;
    do_write(5'h04, 32'h1234_5678, 4'hF, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; bready = 1'b1;
    model_reset();
    wait_nb();
    chk("R10", "bvalid after mid reset", {31'h0, bvalid}, 32'h0);
    check_active("R10");
    do_read(5'h00, "R10");
    do_read(5'h04, "R10");
    repeat (3) wait_nb();

    chk("R8", "read queue drained", rd_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule